// File: doc/BRIEF.md
# Fixed-Latency Memory Response Emulator

This block stands in for the external memory that sits behind a cache during system tests, and it can be synthesized. It takes one line-wide request per cycle on a valid/ready port. Each request carries a line address, a direction flag, per-byte enables, a data line and a tag. Writes update a small internal array of lines under their byte enables and produce no reply. A read copies the addressed line and its tag into a pending queue. The stored line then comes back, with that tag, on a valid/ready response port once a fixed number of cycles has passed.

Every pending read counts down on its own. In a given cycle the block returns the oldest read whose count has run out, so replies come out in the order their wait ends, one per cycle. Back-pressure on the request side comes from two sources: a full pending queue, and an optional stall pattern that blocks requests on every cycle whose index is a multiple of a configured modulus. The pattern lets a test exercise how a cache reacts to a stalling memory.

Top module: `latmem_emu`

## Requirements
- R1: After reset, with the stall pattern off, `rsp_valid` is 0 even while `rsp_ready` is 1, and `req_ready` is 1.
- R2: A read accepted in cycle k appears on the response port in cycle k+1+LATENCY when `rsp_ready` is 1. It carries the line stored at `req_addr` and the request's tag, it is absent in cycles k+1 to k+LATENCY, and it is sent exactly once.
- R3: `rsp_valid` is 0 in every cycle where `rsp_ready` is 0. A read that is due and held back this way stays pending and is sent in the first cycle `rsp_ready` is 1.
- R4: When several reads are due, the oldest accepted one is sent first and one is sent per cycle. Back-to-back reads therefore return in acceptance order, whether or not they were held back.
- R5: An accepted write (`req_write`=1) sets byte b of the line, bits 8b+7 to 8b, to `req_data` bits 8b+7 to 8b only when `req_byteen` bit b is 1. The other bytes keep their values, and a write never produces a response.
- R6: While Q_LIMIT reads are pending, `req_ready` is 0. That includes the cycle in which one of them is being sent. A request offered while `req_ready` is 0 is neither stored nor queued.
- R7: With `stall_en` at 1, `req_ready` is 0 in each cycle whose index is a multiple of STALL_MOD. The index counts from 0, where cycle 0 is the first cycle with `rst` low. A write offered in such a cycle does not change the storage.
- R8: Reset drops all pending reads and restarts the cycle index at 0, but it leaves the storage contents unchanged.
- R9: The data returned for a read is the line as it stood when the read was accepted. A later write to the same line does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall_en | input | 1 | Turns on the periodic request stall pattern |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line address |
| req_byteen | input | LINE_BYTES | Per-byte write enables, bit b covers byte b |
| req_data | input | 8*LINE_BYTES | Write data line |
| req_tag | input | TAG_W | Request tag, returned with read data |
| rsp_ready | input | 1 | Consumer can take a response |
| rsp_valid | output | 1 | Response present (implies rsp_ready) |
| rsp_data | output | 8*LINE_BYTES | Read data line |
| rsp_tag | output | TAG_W | Tag of the returned read |

## Verification
The assertions check four things on every cycle: occupancy never exceeds the queue limit, a read is never accepted into a full queue, a due read that is held back stays due, and an accepted write leaves the occupancy untouched. The exact response cycle, the data and tag of each reply, the order among several due reads, and the byte-enable merge are shown only by the directed scenarios. The same holds for the phase of the stall pattern after reset, the dropping of stalled requests, and the storage surviving reset. All of these are checked against a model of the storage kept in the bench.

// File: rtl/latmem_pkg.sv
package latmem_pkg;

   // Index width for a range of n values, never below one bit.
   function automatic int unsigned width_of(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } req_op_e;

endpackage

// File: rtl/latmem_store.sv
module latmem_store
   import latmem_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned LINE_BYTES = 8
) (
   input  logic                      clk,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [LINE_BYTES-1:0]     be,
   input  logic [8*LINE_BYTES-1:0]   wdata,
   output logic [8*LINE_BYTES-1:0]   rdata
);
   localparam int unsigned LINES = 1 << ADDR_W;

   // One array per byte lane: each lane has a single writer.
   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
      logic [7:0] lane_mem [LINES];

      always_ff @(posedge clk) begin
         if (we && be[b]) begin
            lane_mem[addr] <= wdata[b*8 +: 8];
         end
      end

      assign rdata[b*8 +: 8] = lane_mem[addr];
   end

endmodule

// File: rtl/latmem_pendq.sv
module latmem_pendq
   import latmem_pkg::*;
#(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned DATA_W = 64,
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned LAT    = 3,
   localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic [TAG_W-1:0]  push_tag,
   input  logic              take,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [TAG_W-1:0]  out_tag,
   output logic [OCC_W-1:0]  occ
);
   localparam int unsigned CW = width_of(LAT + 1);
   localparam int unsigned IW = width_of(DEPTH);

   logic [DEPTH-1:0]  v_q, v_n;
   logic [CW-1:0]     cnt_q [DEPTH];
   logic [CW-1:0]     cnt_n [DEPTH];
   logic [DATA_W-1:0] dat_q [DEPTH];
   logic [DATA_W-1:0] dat_n [DEPTH];
   logic [TAG_W-1:0]  tag_q [DEPTH];
   logic [TAG_W-1:0]  tag_n [DEPTH];
   logic [OCC_W-1:0]  occ_q, occ_n, wr_slot;
   logic [DEPTH-1:0]  due;
   logic [IW-1:0]     sel;
   logic              any_due, pop;

   for (genvar i = 0; i < DEPTH; i++) begin : g_due
      assign due[i] = v_q[i] && (cnt_q[i] == '0);
   end

   // Lowest index wins; the compacted queue keeps it the oldest.
   always_comb begin
      sel = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (due[i]) sel = IW'(i);
      end
   end

   assign any_due   = |due;
   assign pop       = any_due && take;
   assign out_valid = pop;
   assign out_data  = dat_q[sel];
   assign out_tag   = tag_q[sel];
   assign occ       = occ_q;
   assign wr_slot   = occ_q - OCC_W'(pop);
   assign occ_n     = occ_q - OCC_W'(pop) + OCC_W'(push);

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         int nx;
         nx = (i + 1 < DEPTH) ? i + 1 : i;
         if (pop && (i >= int'(sel))) begin
            if (i + 1 < DEPTH) begin
               v_n[i]   = v_q[nx];
               cnt_n[i] = cnt_q[nx];
               dat_n[i] = dat_q[nx];
               tag_n[i] = tag_q[nx];
            end else begin
               v_n[i]   = 1'b0;
               cnt_n[i] = '0;
               dat_n[i] = '0;
               tag_n[i] = '0;
            end
         end else begin
            v_n[i]   = v_q[i];
            cnt_n[i] = cnt_q[i];
            dat_n[i] = dat_q[i];
            tag_n[i] = tag_q[i];
         end
         if (cnt_n[i] != '0) cnt_n[i] = cnt_n[i] - 1'b1;
         if (push && (OCC_W'(i) == wr_slot)) begin
            v_n[i]   = 1'b1;
            cnt_n[i] = CW'(LAT);
            dat_n[i] = push_data;
            tag_n[i] = push_tag;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q   <= '0;
         occ_q <= '0;
      end else begin
         v_q   <= v_n;
         occ_q <= occ_n;
      end
   end

   always_ff @(posedge clk) begin
      cnt_q <= cnt_n;
      dat_q <= dat_n;
      tag_q <= tag_n;
   end

   // R6: occupancy stays within the queue
   assert_occ_bound_R6: assert property (@(posedge clk) disable iff (rst)
      occ_q <= OCC_W'(DEPTH));

   // R3: a due read held back by the consumer is still due next cycle
   assert_due_held_R3: assert property (@(posedge clk) disable iff (rst)
      (any_due && !take) |=> any_due);

endmodule

// File: rtl/latmem_throttle.sv
module latmem_throttle
   import latmem_pkg::*;
#(
   parameter int unsigned LIMIT = 4,
   parameter int unsigned MOD   = 5,
   parameter int unsigned OCC_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             stall_en,
   input  logic [OCC_W-1:0] occ,
   output logic             stall
);
   logic pattern_hit;

   if (MOD == 1) begin : g_every
      assign pattern_hit = 1'b1;
   end else begin : g_phase
      localparam int unsigned PW = width_of(MOD);
      logic [PW-1:0] phase;

      always_ff @(posedge clk) begin
         if (rst)                         phase <= '0;
         else if (phase == PW'(MOD - 1))  phase <= '0;
         else                             phase <= phase + 1'b1;
      end

      assign pattern_hit = (phase == '0);
   end

   assign stall = (occ >= OCC_W'(LIMIT)) || (stall_en && pattern_hit);

endmodule

// File: rtl/latmem_emu.sv
module latmem_emu
   import latmem_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned LINE_BYTES = 8,
   parameter int unsigned TAG_W      = 4,
   parameter int unsigned LATENCY    = 3,
   parameter int unsigned Q_LIMIT    = 4,
   parameter int unsigned STALL_MOD  = 5
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    stall_en,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_write,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [LINE_BYTES-1:0]   req_byteen,
   input  logic [8*LINE_BYTES-1:0] req_data,
   input  logic [TAG_W-1:0]        req_tag,
   input  logic                    rsp_ready,
   output logic                    rsp_valid,
   output logic [8*LINE_BYTES-1:0] rsp_data,
   output logic [TAG_W-1:0]        rsp_tag
);
   localparam int unsigned DW    = 8 * LINE_BYTES;
   localparam int unsigned OCC_W = $clog2(Q_LIMIT + 1);

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("latmem_emu: ADDR_W must be 1..10");
   end
   if (LINE_BYTES < 1) begin : g_bad_line
      $error("latmem_emu: LINE_BYTES must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("latmem_emu: TAG_W must be at least 1");
   end
   if (Q_LIMIT < 1) begin : g_bad_limit
      $error("latmem_emu: Q_LIMIT must be at least 1");
   end
   if (STALL_MOD < 1) begin : g_bad_mod
      $error("latmem_emu: STALL_MOD must be at least 1");
   end

   req_op_e          op;
   logic             stall, fire, wr_fire, rd_fire;
   logic [DW-1:0]    line_rd;
   logic [OCC_W-1:0] occ;

   assign op        = req_write ? OP_WRITE : OP_READ;
   assign req_ready = !stall;
   assign fire      = req_valid && req_ready;
   assign wr_fire   = fire && (op == OP_WRITE);
   assign rd_fire   = fire && (op == OP_READ);

   latmem_throttle #(
      .LIMIT (Q_LIMIT),
      .MOD   (STALL_MOD),
      .OCC_W (OCC_W)
   ) u_throttle (
      .clk      (clk),
      .rst      (rst),
      .stall_en (stall_en),
      .occ      (occ),
      .stall    (stall)
   );

   latmem_store #(
      .ADDR_W     (ADDR_W),
      .LINE_BYTES (LINE_BYTES)
   ) u_store (
      .clk   (clk),
      .we    (wr_fire),
      .addr  (req_addr),
      .be    (req_byteen),
      .wdata (req_data),
      .rdata (line_rd)
   );

   latmem_pendq #(
      .DEPTH  (Q_LIMIT),
      .DATA_W (DW),
      .TAG_W  (TAG_W),
      .LAT    (LATENCY)
   ) u_pendq (
      .clk       (clk),
      .rst       (rst),
      .push      (rd_fire),
      .push_data (line_rd),
      .push_tag  (req_tag),
      .take      (rsp_ready),
      .out_valid (rsp_valid),
      .out_data  (rsp_data),
      .out_tag   (rsp_tag),
      .occ       (occ)
   );

   // R6: the throttle never lets a read into a full queue
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
      rd_fire |-> (occ < OCC_W'(Q_LIMIT)));

   // R5: an accepted write adds nothing to the pending queue
   assert_write_silent_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_fire && !rsp_valid) |=> (occ == $past(occ)));

endmodule

// File: tb/latmem_emu_test.sv
module latmem_emu_test;
   localparam int AW  = 4;
   localparam int LB  = 8;
   localparam int TW  = 4;
   localparam int LAT = 3;
   localparam int QL  = 4;
   localparam int MOD = 5;

   logic          clk = 1'b0;
   logic          rst, stall_en, req_valid, req_write, rsp_ready;
   logic [AW-1:0] req_addr;
   logic [LB-1:0] req_byteen;
   logic [63:0]   req_data;
   logic [TW-1:0] req_tag;
   logic          req_ready, rsp_valid;
   logic [63:0]   rsp_data;
   logic [TW-1:0] rsp_tag;

   logic [63:0] ref_mem [16];
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   latmem_emu #(.ADDR_W(AW), .LINE_BYTES(LB), .TAG_W(TW), .LATENCY(LAT),
                .Q_LIMIT(QL), .STALL_MOD(MOD)) uut (
      .clk(clk), .rst(rst), .stall_en(stall_en), .req_valid(req_valid),
      .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
      .req_byteen(req_byteen), .req_data(req_data), .req_tag(req_tag),
      .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_tag(rsp_tag));

   task automatic chk(input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic do_reset(input logic se);
      stall_en = se; rst = 1'b1; req_valid = 1'b0; rsp_ready = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic send_write(input logic [AW-1:0] a, input logic [LB-1:0] be,
                             input logic [63:0] d);
      logic acc;
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_byteen = be; req_data = d;
      #1 acc = req_ready;
      @(negedge clk);
      req_valid = 1'b0;
      if (acc) begin
         for (int b = 0; b < LB; b++)
            if (be[b]) ref_mem[a][b*8 +: 8] = d[b*8 +: 8];
      end
   endtask

   task automatic send_read(input logic [AW-1:0] a, input logic [TW-1:0] t,
                            output logic acc);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_tag = t;
      req_byteen = '0;
      #1 acc = req_ready;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string rq, input logic [AW-1:0] a,
                             input logic [TW-1:0] t);
      #1;
      chk(rq, "rsp_valid", {63'd0, rsp_valid}, 64'd1);
      chk(rq, "rsp_tag", {60'd0, rsp_tag}, {60'd0, t});
      chk(rq, "rsp_data", rsp_data, ref_mem[a]);
   endtask

   task automatic expect_idle(input string rq);
      #1 chk(rq, "rsp_valid idle", {63'd0, rsp_valid}, 64'd0);
   endtask

   // R2: read latency, data and tag, single delivery
   task automatic read_check(input string rq, input logic [AW-1:0] a,
                             input logic [TW-1:0] t);
      logic acc;
      rsp_ready = 1'b1;
      send_read(a, t, acc);
      chk(rq, "read accepted", {63'd0, acc}, 64'd1);
      for (int n = 0; n < LAT; n++) begin
         expect_idle(rq);
         @(negedge clk);
      end
      expect_rsp(rq, a, t);
      @(negedge clk);
      expect_idle(rq);
   endtask

   task automatic t_reset();
      rsp_ready = 1'b1;
      #1;
      chk("R1", "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
      chk("R1", "req_ready after reset", {63'd0, req_ready}, 64'd1);
      @(negedge clk);
   endtask

   task automatic t_write_read();
      send_write(4'd3, 8'hFF, 64'h1122_3344_5566_7788);
      send_write(4'd5, 8'hFF, 64'hAAAA_AAAA_AAAA_AAAA);
      send_write(4'd5, 8'b0000_0101, 64'h0102_0304_0506_0708);
      chk("R5", "model merge", ref_mem[5], 64'hAAAA_AAAA_AA06_AA08);
      read_check("R2", 4'd3, 4'd7);
      read_check("R5", 4'd5, 4'd2);
   endtask

   task automatic t_write_silent();
      rsp_ready = 1'b1;
      send_write(4'd7, 8'hF0, 64'hCAFE_0000_0000_0000);
      for (int n = 0; n < LAT + 3; n++) begin
         expect_idle("R5");
         @(negedge clk);
      end
   endtask

   task automatic t_backpressure();
      logic acc;
      rsp_ready = 1'b0;
      send_read(4'd3, 4'd9, acc);
      for (int n = 0; n < 5; n++) begin
         #1 chk("R3", "rsp_valid while not ready", {63'd0, rsp_valid}, 64'd0);
         @(negedge clk);
      end
      rsp_ready = 1'b1;
      expect_rsp("R3", 4'd3, 4'd9);
      @(negedge clk);
      expect_idle("R3");
   endtask

   task automatic t_order();
      logic acc;
      rsp_ready = 1'b1;
      send_read(4'd3, 4'd1, acc);
      send_read(4'd5, 4'd2, acc);
      send_read(4'd7, 4'd3, acc);
      expect_idle("R4");
      @(negedge clk); expect_rsp("R4", 4'd3, 4'd1);
      @(negedge clk); expect_rsp("R4", 4'd5, 4'd2);
      @(negedge clk); expect_rsp("R4", 4'd7, 4'd3);
      @(negedge clk); expect_idle("R4");
   endtask

   task automatic t_held_order();
      logic acc;
      rsp_ready = 1'b0;
      send_read(4'd7, 4'd4, acc);
      send_read(4'd3, 4'd5, acc);
      send_read(4'd5, 4'd6, acc);
      repeat (4) @(negedge clk);
      rsp_ready = 1'b1;
      expect_rsp("R4", 4'd7, 4'd4);
      @(negedge clk); expect_rsp("R4", 4'd3, 4'd5);
      @(negedge clk); expect_rsp("R4", 4'd5, 4'd6);
      @(negedge clk); expect_idle("R4");
   endtask

   task automatic t_limit();
      logic acc;
      send_write(4'd9, 8'hFF, 64'h0F0E_0D0C_0B0A_0908);
      rsp_ready = 1'b0;
      for (int n = 0; n < QL; n++) begin
         send_read(4'd9, TW'(8 + n), acc);
         chk("R6", "read below limit accepted", {63'd0, acc}, 64'd1);
      end
      req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd9;
      req_byteen = 8'hFF; req_data = 64'hDEAD_BEEF_DEAD_BEEF;
      #1 chk("R6", "req_ready at limit", {63'd0, req_ready}, 64'd0);
      @(negedge clk);
      #1 chk("R6", "req_ready at limit", {63'd0, req_ready}, 64'd0);
      @(negedge clk);
      req_valid = 1'b0;
      rsp_ready = 1'b1;
      expect_rsp("R6", 4'd9, 4'd8);
      chk("R6", "req_ready while draining", {63'd0, req_ready}, 64'd0);
      @(negedge clk);
      expect_rsp("R6", 4'd9, 4'd9);
      chk("R6", "req_ready after one left", {63'd0, req_ready}, 64'd1);
      @(negedge clk); expect_rsp("R6", 4'd9, 4'd10);
      @(negedge clk); expect_rsp("R6", 4'd9, 4'd11);
      @(negedge clk); expect_idle("R6");
      read_check("R6", 4'd9, 4'd12);
   endtask

   task automatic t_capture();
      logic acc;
      logic [63:0] old_line;
      send_write(4'd11, 8'hFF, 64'h1111_2222_3333_4444);
      old_line = ref_mem[11];
      rsp_ready = 1'b1;
      send_read(4'd11, 4'd13, acc);
      send_write(4'd11, 8'hFF, 64'h5555_6666_7777_8888);
      expect_idle("R9");
      @(negedge clk);
      expect_idle("R9");
      @(negedge clk);
      #1;
      chk("R9", "rsp_valid", {63'd0, rsp_valid}, 64'd1);
      chk("R9", "data at acceptance", rsp_data, old_line);
      chk("R9", "tag", {60'd0, rsp_tag}, 64'd13);
      @(negedge clk);
      read_check("R9", 4'd11, 4'd14);
   endtask

   task automatic t_stall_reset();
      logic acc;
      rsp_ready = 1'b1;
      send_write(4'd2, 8'hFF, 64'h0123_4567_89AB_CDEF);
      rsp_ready = 1'b0;
      send_read(4'd2, 4'd15, acc);
      @(negedge clk);
      do_reset(1'b1);
      rsp_ready = 1'b1;
      for (int idx = 0; idx < 12; idx++) begin
         if (idx == 5) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd2;
            req_byteen = 8'hFF; req_data = 64'hFFFF_0000_FFFF_0000;
         end else begin
            req_valid = 1'b0;
         end
         #1;
         chk("R7", $sformatf("req_ready idx %0d", idx), {63'd0, req_ready},
             (idx % MOD == 0) ? 64'd0 : 64'd1);
         chk("R8", "queue cleared by reset", {63'd0, rsp_valid}, 64'd0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      stall_en = 1'b0;
      read_check("R8", 4'd2, 4'd1);
   endtask

   initial begin
      rst = 1'b1; stall_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_byteen = '0; req_data = '0; req_tag = '0; rsp_ready = 1'b0;
      @(negedge clk);
      do_reset(1'b0);
      t_reset();
      t_write_read();
      t_write_silent();
      t_backpressure();
      t_order();
      t_held_order();
      t_limit();
      t_capture();
      t_stall_reset();
      finish_run();
   end

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule